// File: doc/BRIEF.md
# Page Write Load Controller

This controller sits between a parallel memory bus and a non-volatile storage array that is programmed one page at a time. The bus uses an active-low write strobe. The controller collects the individual byte writes into a page buffer. The upper address bits of the first byte fix the page. Each later byte must follow the previous strobe within a short spacing window.

When the strobe stays idle for a quiet window, the load closes. The controller then presents the page address, a byte-enable mask and the buffered data on a one-cycle commit pulse. After that it runs a timed programming interval and ends it with a done pulse.

Every timeout is counted in ticks of an external microsecond tick input. The tick counts are parameters. An asynchronous active-low reset aborts a load or a programming interval at any point.

Top module: `page_write_loader`

## Requirements
- R1: The address splits into a 6-bit byte offset (bits 5:0) and a 9-bit page number (bits 14:6). Byte i of the page appears on `commitData[8*i+7:8*i]`, and its enable appears on `commitMask[i]`.
- R2: The page number is taken from the first strobe of a load. The upper address bits of every later strobe in the same load have no effect on `commitPage`.
- R3: The byte offset is sampled on the falling edge of `wrStrobeN`, and the data byte is sampled on its rising edge. Address changes after the fall and data changes after the rise are not seen.
- R4: The load closes after QUIET_TICKS ticks during which the strobe is high and no byte is pending. `commitValid` then pulses for one cycle while the commit outputs hold the loaded page.
- R5: Programming lasts PROG_TICKS ticks after the commit. It ends with a one-cycle `progDone` pulse, and `busy` falls in that same cycle.
- R6: `busy` is low after reset. It rises in the cycle after the first strobe fall is sampled and stays high through loading and programming.
- R7: A strobe fall that arrives once GAP_TICKS ticks have elapsed since the previous accepted fall is discarded, and its byte is not enabled.
- R8: Strobes during programming are ignored, and the commit outputs do not change.
- R9: The byte-enable mask is cleared at the start of every new load, so only bytes written in that load are enabled.
- R10: A byte offset written more than once in one load holds the data from its last write.
- R11: While `rstN` is low, `busy` is low, the mask is cleared and no programming completes. A programming interval that is cut by reset never produces `progDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset and abort |
| usTick | input | 1 | One-cycle pulse each microsecond |
| wrStrobeN | input | 1 | Active-low write strobe |
| addrIn | input | 15 | Byte address |
| dataIn | input | 8 | Write data |
| busy | output | 1 | Load or programming in progress |
| commitValid | output | 1 | One-cycle pulse when a page is committed |
| commitPage | output | 9 | Committed page number |
| commitMask | output | 64 | Byte enables of the committed page |
| commitData | output | 512 | Data of the committed page, byte i at bits 8i+7:8i |
| progDone | output | 1 | One-cycle pulse at the end of programming |

## Verification
The bench shortens the timeouts to GAP_TICKS=3, QUIET_TICKS=8 and PROG_TICKS=20, and generates a tick every four clocks. With these values, late bytes, quiet closing, the full programming interval and an abort by reset all happen within a few hundred cycles. The address and data widths keep their defaults, so the 64-byte page, the top offset 63 and the 9-bit page field are exercised as built.

// File: rtl/page_load_pkg.sv
package page_load_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} loadState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capFirst;   // capture page + offset, clear mask
    logic capOffset;  // capture offset only
    logic writeByte;  // store data into the captured offset
  } dpStrobe_t;
endpackage

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
  import page_load_pkg::*;
#(
  parameter int GAP_TICKS   = 30,
  parameter int QUIET_TICKS = 100,
  parameter int PROG_TICKS  = 10000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic       wrStrobeN,
  output dpStrobe_t  strb,
  output logic       busy,
  output logic       commitValid,
  output logic       progDone
);
  localparam int GW = $clog2(GAP_TICKS + 1);
  localparam int QW = $clog2(QUIET_TICKS + 1);
  localparam int PW = $clog2(PROG_TICKS + 1);
  localparam logic [GW-1:0] GAP_LIM   = GW'(GAP_TICKS);
  localparam logic [QW-1:0] QUIET_END = QW'(QUIET_TICKS - 1);
  localparam logic [PW-1:0] PROG_END  = PW'(PROG_TICKS - 1);

  loadState_e state;
  logic strobeQ, pending;
  logic [GW-1:0] gapCnt;
  logic [QW-1:0] quietCnt;
  logic [PW-1:0] progCnt;
  logic fallEdge, riseEdge, closeNow, finishNow;

  assign fallEdge = strobeQ & ~wrStrobeN;
  assign riseEdge = ~strobeQ & wrStrobeN;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb      = '0;
    closeNow  = 1'b0;
    finishNow = 1'b0;
    unique case (state)
      ST_IDLE: strb.capFirst = fallEdge;
      ST_LOAD: begin
        strb.capOffset = fallEdge && !pending && (gapCnt < GAP_LIM);
        strb.writeByte = riseEdge && pending;
        closeNow = !pending && wrStrobeN && usTick && (quietCnt == QUIET_END);
      end
      ST_PROG: finishNow = usTick && (progCnt == PROG_END);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      strobeQ     <= 1'b1;
      pending     <= 1'b0;
      gapCnt      <= '0;
      quietCnt    <= '0;
      progCnt     <= '0;
      commitValid <= 1'b0;
      progDone    <= 1'b0;
    end else begin
      strobeQ     <= wrStrobeN;
      commitValid <= closeNow;
      progDone    <= finishNow;
      unique case (state)
        ST_IDLE: if (strb.capFirst) begin
          state    <= ST_LOAD;
          pending  <= 1'b1;
          gapCnt   <= '0;
          quietCnt <= '0;
        end
        ST_LOAD: begin
          if (strb.capOffset) begin
            pending <= 1'b1;
            gapCnt  <= '0;
          end else if (usTick && gapCnt < GAP_LIM) begin
            gapCnt <= gapCnt + 1'b1;
          end
          if (strb.writeByte) begin
            pending  <= 1'b0;
            quietCnt <= '0;
          end else if (!pending && wrStrobeN && usTick) begin
            quietCnt <= quietCnt + 1'b1;
          end
          if (closeNow) begin
            state   <= ST_PROG;
            progCnt <= '0;
          end
        end
        ST_PROG: begin
          if (usTick) progCnt <= progCnt + 1'b1;
          if (finishNow) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: a commit is issued only while busy
  assert_commit_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> busy);
  // R5: done pulse coincides with release of busy
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    progDone |-> !busy);
  // R6: busy only rises after a sampled strobe fall
  assert_busy_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(fallEdge));
  // R8: no datapath strobe during programming
  assert_no_write_prog_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROG) |-> (strb == '0));
  // R5: commit and done never together
  assert_pulses_apart_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(commitValid && progDone));
endmodule

// File: rtl/page_load_dpath.sv
module page_load_dpath
  import page_load_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 6
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  dpStrobe_t                         strb,
  input  logic [ADDR_W-1:0]                 addrIn,
  input  logic [DATA_W-1:0]                 dataIn,
  output logic [ADDR_W-OFF_W-1:0]           commitPage,
  output logic [(1<<OFF_W)-1:0]             commitMask,
  output logic [(1<<OFF_W)*DATA_W-1:0]      commitData
);
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int PAGE_W     = ADDR_W - OFF_W;

  logic [PAGE_W-1:0] pageReg;
  logic [OFF_W-1:0]  offReg;
  logic [DATA_W-1:0] laneView [PAGE_BYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
      offReg  <= '0;
    end else if (strb.capFirst) begin
      pageReg <= addrIn[ADDR_W-1:OFF_W];
      offReg  <= addrIn[OFF_W-1:0];
    end else if (strb.capOffset) begin
      offReg  <= addrIn[OFF_W-1:0];
    end
  end

  assign commitPage = pageReg;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_lane
    logic              laneVld;
    logic [DATA_W-1:0] laneData;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneVld  <= 1'b0;
        laneData <= '0;
      end else if (strb.capFirst) begin
        laneVld <= 1'b0;
      end else if (strb.writeByte && offReg == OFF_W'(i)) begin
        laneVld  <= 1'b1;
        laneData <= dataIn;
      end
    end
    assign commitMask[i] = laneVld;
    assign commitData[i*DATA_W +: DATA_W] = laneData;
    assign laneView[i] = laneData;
  end

  // R9: a new load starts with an empty mask
  assert_first_clears_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.capFirst |=> (commitMask == '0));
  // R9: a stored byte becomes enabled
  assert_write_sets_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeByte |=> commitMask[$past(offReg)]);
  // R10: a stored byte holds the latest data
  assert_write_data_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeByte |=> (laneView[$past(offReg)] == $past(dataIn)));
endmodule

// File: rtl/page_write_loader.sv
module page_write_loader
  import page_load_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int OFF_W       = 6,
  parameter int GAP_TICKS   = 30,
  parameter int QUIET_TICKS = 100,
  parameter int PROG_TICKS  = 10000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          usTick,
  input  logic                          wrStrobeN,
  input  logic [ADDR_W-1:0]             addrIn,
  input  logic [DATA_W-1:0]             dataIn,
  output logic                          busy,
  output logic                          commitValid,
  output logic [ADDR_W-OFF_W-1:0]       commitPage,
  output logic [(1<<OFF_W)-1:0]         commitMask,
  output logic [(1<<OFF_W)*DATA_W-1:0]  commitData,
  output logic                          progDone
);
  dpStrobe_t strb;

  page_load_ctrl #(
    .GAP_TICKS(GAP_TICKS), .QUIET_TICKS(QUIET_TICKS), .PROG_TICKS(PROG_TICKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .usTick(usTick), .wrStrobeN(wrStrobeN),
    .strb(strb), .busy(busy), .commitValid(commitValid), .progDone(progDone)
  );

  page_load_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIn(addrIn), .dataIn(dataIn),
    .commitPage(commitPage), .commitMask(commitMask), .commitData(commitData)
  );
endmodule

// File: tb/page_write_loader_bench.sv
module page_write_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int GAP_T      = 3;
  localparam int QUIET_T    = 8;
  localparam int PROG_T     = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b0;
  logic wrStrobeN = 1'b1;
  logic [14:0] addrIn = '0;
  logic [7:0]  dataIn = '0;
  logic busy, commitValid, progDone;
  logic [8:0]   commitPage;
  logic [63:0]  commitMask;
  logic [511:0] commitData;

  int checks = 0;
  int errors = 0;
  int divCnt = 0;

  page_write_loader #(
    .GAP_TICKS(GAP_T), .QUIET_TICKS(QUIET_T), .PROG_TICKS(PROG_T)
  ) u_page_write_loader (
    .clk(clk), .rstN(rstN), .usTick(usTick), .wrStrobeN(wrStrobeN),
    .addrIn(addrIn), .dataIn(dataIn), .busy(busy), .commitValid(commitValid),
    .commitPage(commitPage), .commitMask(commitMask), .commitData(commitData),
    .progDone(progDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    divCnt <= (divCnt == TICK_DIV-1) ? 0 : divCnt + 1;
    usTick <= (divCnt == TICK_DIV-1);
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // offset sampled at fall, data at rise; address and data scrambled afterwards
  task automatic writeByte(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk); addrIn = a; dataIn = ~d; wrStrobeN = 1'b0;
    @(negedge clk); addrIn = ~a; dataIn = d; wrStrobeN = 1'b1;
    @(negedge clk); dataIn = ~d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitCommit(output int cyc);
    cyc = 0;
    while (commitValid !== 1'b1 && cyc < 500) begin @(negedge clk); cyc++; end
  endtask

  task automatic waitDone(output int cyc);
    cyc = 0;
    @(negedge clk);
    while (progDone !== 1'b1 && cyc < 500) begin @(negedge clk); cyc++; end
  endtask

  function automatic logic [7:0] lane(input int i);
    return commitData[i*8 +: 8];
  endfunction

  task automatic t_reset();
    check(busy == 1'b0, "R6 busy after reset", busy, 0);
    check(commitMask == '0, "R11 mask after reset", commitMask, 0);
    check(!commitValid && !progDone, "R11 no pulses in reset", {commitValid, progDone}, 0);
  endtask

  task automatic t_basic();
    int cyc;
    logic [63:0] maskSnap;
    logic [511:0] dataSnap;
    writeByte({9'h12A, 6'd5}, 8'hA5);
    check(busy == 1'b1, "R6 busy after first byte", busy, 1);
    idle(2);
    writeByte({9'h055, 6'd6}, 8'h3C);   // different upper bits: R2
    idle(2);
    writeByte({9'h1FF, 6'd63}, 8'hE7);
    waitCommit(cyc);
    check(cyc >= 25 && cyc <= 40, "R4 quiet close timing", cyc, QUIET_T*TICK_DIV);
    check(commitPage == 9'h12A, "R2 page frozen by first byte", commitPage, 9'h12A);
    check(commitMask == ((64'd1 << 5) | (64'd1 << 6) | (64'd1 << 63)), "R1 mask lanes",
          commitMask, (64'd1 << 5) | (64'd1 << 6) | (64'd1 << 63));
    check(lane(5) == 8'hA5 && lane(6) == 8'h3C, "R3 data at rise lanes 5/6",
          {lane(5), lane(6)}, 16'hA53C);
    check(lane(63) == 8'hE7, "R1 top lane 63", lane(63), 8'hE7);
    maskSnap = commitMask;
    dataSnap = commitData;
    idle(3);
    writeByte({9'h001, 6'd0}, 8'h99);
    idle(2);
    check(commitMask == maskSnap && commitData == dataSnap && commitPage == 9'h12A,
          "R8 strobe during programming ignored", commitMask, maskSnap);
    check(busy == 1'b1, "R6 busy during programming", busy, 1);
    waitDone(cyc);
    check(cyc + 11 >= 74 && cyc + 11 <= 90, "R5 programming length", cyc + 11, PROG_T*TICK_DIV);
    check(busy == 1'b0, "R5 busy released with done", busy, 0);
    @(negedge clk);
    check(progDone == 1'b0, "R5 done is one cycle", progDone, 0);
  endtask

  task automatic t_repeat();
    int cyc;
    writeByte({9'h0F0, 6'd0}, 8'h11);
    idle(2);
    writeByte({9'h0F0, 6'd1}, 8'h22);
    idle(2);
    writeByte({9'h0F0, 6'd0}, 8'h33);
    waitCommit(cyc);
    check(commitMask == 64'h3, "R9 mask cleared for new load", commitMask, 64'h3);
    check(lane(0) == 8'h33, "R10 last write wins", lane(0), 8'h33);
    check(lane(1) == 8'h22, "R10 other lane intact", lane(1), 8'h22);
    waitDone(cyc);
  endtask

  task automatic t_gap();
    int cyc;
    writeByte({9'h003, 6'd2}, 8'h44);
    idle(5);
    writeByte({9'h003, 6'd4}, 8'h55);
    idle(20);
    writeByte({9'h003, 6'd3}, 8'h66);
    waitCommit(cyc);
    check(commitMask[4] == 1'b1, "R7 byte inside spacing accepted", commitMask[4], 1);
    check(commitMask == 64'h14, "R7 late byte discarded", commitMask, 64'h14);
    waitDone(cyc);
  endtask

  task automatic t_abort();
    int cyc;
    int seen = 0;
    writeByte({9'h077, 6'd9}, 8'h5A);
    waitCommit(cyc);
    idle(10);
    rstN = 1'b0;
    idle(2);
    check(busy == 1'b0, "R11 busy low in reset", busy, 0);
    check(commitMask == '0, "R11 mask cleared by reset", commitMask, 0);
    rstN = 1'b1;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (progDone) seen++;
    end
    check(seen == 0, "R11 aborted programming never completes", seen, 0);
    check(busy == 1'b0, "R11 idle after abort", busy, 0);
  endtask

  initial begin
    idle(3);
    t_reset();
    rstN = 1'b1;
    idle(4);
    t_basic();
    t_repeat();
    t_gap();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule